// File: doc/BRIEF.md
# XY Wormhole Route Stage for a Mesh Router Input Port

This block is the route-computation stage that sits behind the input buffer of one port of a five-port mesh router. Each cycle it may take one flit with a valid strobe. When the flit is a packet head, the block compares the destination coordinates in that flit with the router's own coordinates, using dimension-ordered routing (column first, then row). It then sends the flit to one of four outgoing lines, each wired through the crossbar to the scheduler of one of the other ports. The chosen line is kept for every later flit of the same packet, until the closing flit has gone through.

A port never routes back to its own direction, so the four lines stand for the other four directions. The order is North, East, South, West, Local, with the port's own direction removed. Flits that do not fit the wormhole sequence are dropped and reported with a one-cycle error pulse. These are continuation flits with no path open, heads that arrive while a path is open, heads that would turn back, and reserved kinds. Outputs are registered, so a flit taken in one cycle appears on its line in the next cycle.

Top module: `xy_wormhole_outcalc`

## Requirements
- R1: While `rst` is high, and in the cycle after it, `out_vld`, `out_req` and `err` are all zero, and any path that was open is forgotten.
- R2: A head flit (bits [7:6] = 01; destination column in bit 0, destination row in bit 1) is routed as follows. If the destination column is greater than `my_x` it goes East, and if smaller it goes West. Only when the columns match is the row compared: South if the row is greater than `my_y`, North if smaller. Local is chosen when both match. With the default Local port, lines 0..3 are North, East, South, West.
- R3: An accepted flit appears unmodified on exactly one line, with its `out_vld` bit high, in the cycle after it was presented.
- R4: Body flits (10) and tail flits (11) leave on the line their head took, whatever their other bits hold.
- R5: The `out_req` bit of the chosen line stays high from the cycle the head appears until the cycle the tail appears, including idle gaps. It is low in the following cycle unless a new head is routed.
- R6: A head presented in the cycle right after a tail is routed afresh, possibly to a different line.
- R7: A body or tail with no open path is dropped, and `err` pulses in the next cycle.
- R8: A head that arrives while a path is open is dropped and pulses `err`. The open path and its `out_req` are kept.
- R9: A head whose route equals the port's own direction is dropped, pulses `err`, and opens no path.
- R10: A flit of the reserved kind 00 is dropped, pulses `err`, and leaves any open path unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 1 | A flit is presented this cycle |
| in_flit | input | FW | Flit from the input buffer |
| my_x | input | CW | Column of this router |
| my_y | input | CW | Row of this router |
| out_vld | output | 4 | Flit present on each outgoing line |
| out_req | output | 4 | Path held on each outgoing line |
| out_flit | output | 4*FW | Flit bus per line, line k at bits [k*FW +: FW] |
| err | output | 1 | One-cycle pulse for a dropped flit |

## Verification
The cases that are hardest to reach from the ports are the malformed sequences. Examples are a head that lands in the middle of an open packet, a continuation flit left behind when a reset erased its path, and a head aimed at the port's own direction. With the default Local port, that last case happens only when the destination equals the router's coordinates. The stimulus reaches these cases on purpose: it places a second head between a head and its tail, resets after a lone head, and sets the coordinate inputs equal to the destination. A reference model in the bench tracks the open path, so every cycle's lines, request bits and error pulse are predicted, idle gaps included.

// File: rtl/noc_xy_pkg.sv
package noc_xy_pkg;

    localparam int unsigned NUM_DIRS = 5;
    localparam int unsigned NUM_OUTS = NUM_DIRS - 1;

    typedef enum logic [2:0] {
        DIR_N = 3'd0,
        DIR_E = 3'd1,
        DIR_S = 3'd2,
        DIR_W = 3'd3,
        DIR_L = 3'd4
    } dir_e;

    typedef enum logic [1:0] {
        KIND_RSVD = 2'b00,
        KIND_HEAD = 2'b01,
        KIND_BODY = 2'b10,
        KIND_TAIL = 2'b11
    } kind_e;

    // Decision of the control stage for one input cycle
    typedef struct packed {
        logic fwd;
        dir_e fwd_dir;
        logic held;
        dir_e held_dir;
        logic err;
    } steer_t;

    // Direction served by outgoing line k when the port's own direction is skipped
    function automatic dir_e lane_dir(int unsigned k, dir_e own);
        if (k < int'(own))
            return dir_e'(k);
        else
            return dir_e'(k + 1);
    endfunction

endpackage

// File: rtl/xyoc_route_calc.sv
module xyoc_route_calc
    import noc_xy_pkg::*;
#(
    parameter int unsigned CW = 1
) (
    input  logic [CW-1:0] my_x,
    input  logic [CW-1:0] my_y,
    input  logic [CW-1:0] dst_x,
    input  logic [CW-1:0] dst_y,
    output dir_e          dir
);
    always_comb begin
        if (dst_x > my_x)
            dir = DIR_E;
        else if (dst_x < my_x)
            dir = DIR_W;
        else if (dst_y > my_y)
            dir = DIR_S;
        else if (dst_y < my_y)
            dir = DIR_N;
        else
            dir = DIR_L;
    end
endmodule

// File: rtl/xyoc_wormhole_ctrl.sv
module xyoc_wormhole_ctrl
    import noc_xy_pkg::*;
#(
    parameter dir_e OWN_DIR = DIR_L
) (
    input  logic   clk,
    input  logic   rst,
    input  logic   in_vld,
    input  kind_e  kind,
    input  dir_e   hdr_dir,
    output steer_t steer
);
    logic lock_on;
    dir_e lock_dir;
    logic nxt_lock;
    dir_e nxt_dir;

    always_comb begin
        steer.fwd      = 1'b0;
        steer.fwd_dir  = lock_dir;
        steer.held     = lock_on;
        steer.held_dir = lock_dir;
        steer.err      = 1'b0;
        nxt_lock       = lock_on;
        nxt_dir        = lock_dir;
        if (in_vld) begin
            unique case (kind)
                KIND_HEAD: begin
                    if (lock_on || hdr_dir == OWN_DIR) begin
                        steer.err = 1'b1;
                    end else begin
                        steer.fwd     = 1'b1;
                        steer.fwd_dir = hdr_dir;
                        nxt_lock      = 1'b1;
                        nxt_dir       = hdr_dir;
                    end
                end
                KIND_BODY: begin
                    if (lock_on) steer.fwd = 1'b1;
                    else         steer.err = 1'b1;
                end
                KIND_TAIL: begin
                    if (lock_on) begin
                        steer.fwd = 1'b1;
                        nxt_lock  = 1'b0;
                    end else begin
                        steer.err = 1'b1;
                    end
                end
                default: steer.err = 1'b1;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            lock_on  <= 1'b0;
            lock_dir <= DIR_L;
        end else begin
            lock_on  <= nxt_lock;
            lock_dir <= nxt_dir;
        end
    end
endmodule

// File: rtl/xyoc_out_lanes.sv
module xyoc_out_lanes
    import noc_xy_pkg::*;
#(
    parameter int unsigned FW      = 8,
    parameter dir_e        OWN_DIR = DIR_L
) (
    input  logic                   clk,
    input  logic                   rst,
    input  steer_t                 steer,
    input  logic [FW-1:0]          flit,
    output logic [NUM_OUTS-1:0]    vld,
    output logic [NUM_OUTS-1:0]    req,
    output logic [NUM_OUTS*FW-1:0] flits,
    output logic                   err
);
    for (genvar k = 0; k < NUM_OUTS; k++) begin : g_lane
        localparam dir_e LANE_DIR = lane_dir(k, OWN_DIR);
        logic hit_fwd;
        logic hit_held;

        assign hit_fwd  = steer.fwd  && (steer.fwd_dir  == LANE_DIR);
        assign hit_held = steer.held && (steer.held_dir == LANE_DIR);

        always_ff @(posedge clk) begin
            if (rst) begin
                vld[k]             <= 1'b0;
                req[k]             <= 1'b0;
                flits[k*FW +: FW]  <= '0;
            end else begin
                vld[k] <= hit_fwd;
                req[k] <= steer.fwd ? hit_fwd : hit_held;
                if (hit_fwd)
                    flits[k*FW +: FW] <= flit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) err <= 1'b0;
        else     err <= steer.err;
    end
endmodule

// File: rtl/xy_wormhole_outcalc.sv
module xy_wormhole_outcalc
    import noc_xy_pkg::*;
#(
    parameter int unsigned FW      = 8,
    parameter int unsigned CW      = 1,
    parameter dir_e        OWN_DIR = DIR_L
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            in_vld,
    input  logic [FW-1:0]   in_flit,
    input  logic [CW-1:0]   my_x,
    input  logic [CW-1:0]   my_y,
    output logic [3:0]      out_vld,
    output logic [3:0]      out_req,
    output logic [4*FW-1:0] out_flit,
    output logic            err
);
    kind_e  kind;
    dir_e   hdr_dir;
    steer_t steer;

    assign kind = kind_e'(in_flit[FW-1 -: 2]);

    xyoc_route_calc #(.CW(CW)) u_route (
        .my_x  (my_x),
        .my_y  (my_y),
        .dst_x (in_flit[CW-1:0]),
        .dst_y (in_flit[2*CW-1:CW]),
        .dir   (hdr_dir)
    );

    xyoc_wormhole_ctrl #(.OWN_DIR(OWN_DIR)) u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .in_vld  (in_vld),
        .kind    (kind),
        .hdr_dir (hdr_dir),
        .steer   (steer)
    );

    xyoc_out_lanes #(.FW(FW), .OWN_DIR(OWN_DIR)) u_lanes (
        .clk   (clk),
        .rst   (rst),
        .steer (steer),
        .flit  (in_flit),
        .vld   (out_vld),
        .req   (out_req),
        .flits (out_flit),
        .err   (err)
    );
endmodule

// File: rtl/xyoc_checker.sv
module xyoc_checker #(
    parameter int unsigned FW = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            in_vld,
    input logic [FW-1:0]   in_flit,
    input logic [3:0]      out_vld,
    input logic [3:0]      out_req,
    input logic [4*FW-1:0] out_flit,
    input logic            err
);
    logic [FW-1:0] sel_flit;
    always_comb begin
        sel_flit = '0;
        for (int k = 0; k < 4; k++)
            if (out_vld[k]) sel_flit = out_flit[k*FW +: FW];
    end

    // R1: outputs quiet right after reset
    a_r1_reset_quiet: assert property (@(posedge clk)
        rst |=> (out_vld == 4'b0 && out_req == 4'b0 && !err));

    // R3: at most one line carries a flit, and only a line holding the path
    a_r3_one_line: assert property (@(posedge clk) disable iff (rst)
        $onehot0(out_vld) && $onehot0(out_req) && ((out_vld & ~out_req) == 4'b0));

    // R3: forwarded flit equals the one presented a cycle earlier
    a_r3_data_intact: assert property (@(posedge clk) disable iff (rst)
        (|out_vld) |-> ($past(in_vld) && sel_flit == $past(in_flit)));

    // R5: path request held until the tail has gone out
    a_r5_req_hold: assert property (@(posedge clk) disable iff (rst)
        ((|out_req) && !((|out_vld) && sel_flit[FW-1 -: 2] == 2'b11)) |=> $stable(out_req));

    // R7: an error pulse follows a presented flit and never coincides with a forward
    a_r7_err_source: assert property (@(posedge clk) disable iff (rst)
        err |-> ($past(in_vld) && out_vld == 4'b0));
endmodule

bind xy_wormhole_outcalc xyoc_checker #(.FW(FW)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .in_vld   (in_vld),
    .in_flit  (in_flit),
    .out_vld  (out_vld),
    .out_req  (out_req),
    .out_flit (out_flit),
    .err      (err)
);

// File: tb/xy_wormhole_outcalc_tb.sv
module xy_wormhole_outcalc_tb;
    localparam int CLK_PERIOD = 10;
    localparam int FW = 8;
    localparam int CW = 1;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            in_vld = 1'b0;
    logic [FW-1:0]   in_flit = '0;
    logic [CW-1:0]   my_x = '0;
    logic [CW-1:0]   my_y = '0;
    logic [3:0]      out_vld;
    logic [3:0]      out_req;
    logic [4*FW-1:0] out_flit;
    logic            err;

    int n_checks = 0;
    int n_fails  = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    xy_wormhole_outcalc #(.FW(FW), .CW(CW)) u_dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_flit(in_flit),
        .my_x(my_x), .my_y(my_y), .out_vld(out_vld), .out_req(out_req),
        .out_flit(out_flit), .err(err)
    );

    typedef struct {
        logic [3:0]    vld;
        logic [3:0]    req;
        logic [FW-1:0] flit;
        logic          err;
        string         tag;
    } exp_t;

    exp_t exp_q[$];

    // reference model of the open path; lines 0..3 = N,E,S,W (Local is own)
    bit m_lock = 0;
    int m_line = 0;

    function automatic logic [FW-1:0] head(int x, int y);
        return {2'b01, 4'b1010, 1'(y), 1'(x)};
    endfunction
    function automatic logic [FW-1:0] body(logic [5:0] p);
        return {2'b10, p};
    endfunction
    function automatic logic [FW-1:0] tail(logic [5:0] p);
        return {2'b11, p};
    endfunction

    // 0=N 1=E 2=S 3=W 4=Local
    function automatic int xy_dir(int dx, int dy);
        if (dx > int'(my_x)) return 1;
        if (dx < int'(my_x)) return 3;
        if (dy > int'(my_y)) return 2;
        if (dy < int'(my_y)) return 0;
        return 4;
    endfunction

    task automatic check(bit ok, string tag, string what, logic [31:0] act, logic [31:0] expv);
        n_checks++;
        if (!ok) begin
            n_fails++;
            $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
        end
    endtask

    task automatic drive(bit v, logic [FW-1:0] f, string tag);
        exp_t e;
        @(negedge clk);
        in_vld  = v;
        in_flit = f;
        e.vld = 4'b0; e.err = 1'b0; e.flit = f; e.tag = tag;
        e.req = m_lock ? 4'(1 << m_line) : 4'b0;
        if (v) begin
            case (f[7:6])
                2'b01: begin
                    int d;
                    d = xy_dir(int'(f[0]), int'(f[1]));
                    if (m_lock || d == 4) e.err = 1'b1;
                    else begin
                        m_lock = 1; m_line = d;
                        e.vld = 4'(1 << d); e.req = 4'(1 << d);
                    end
                end
                2'b10: begin
                    if (m_lock) e.vld = 4'(1 << m_line);
                    else        e.err = 1'b1;
                end
                2'b11: begin
                    if (m_lock) begin
                        e.vld = 4'(1 << m_line);
                        m_lock = 0;
                    end else e.err = 1'b1;
                end
                default: e.err = 1'b1;
            endcase
        end
        exp_q.push_back(e);
    endtask

    task automatic idle(int n, string tag);
        for (int i = 0; i < n; i++) drive(1'b0, '0, tag);
    endtask

    task automatic packet(int x, int y, int gap, string tag);
        drive(1'b1, head(x, y), tag);
        idle(gap, tag);
        drive(1'b1, body(6'h15), tag);
        idle(gap, tag);
        drive(1'b1, tail(6'h2a), tag);
    endtask

    // monitor: compare each cycle's outputs with the queued expectation
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && exp_q.size() > 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(out_vld == e.vld, e.tag, "out_vld", 32'(out_vld), 32'(e.vld));
                check(out_req == e.req, e.tag, "out_req", 32'(out_req), 32'(e.req));
                check(err == e.err, e.tag, "err", 32'(err), 32'(e.err));
                for (int k = 0; k < 4; k++)
                    if (e.vld[k])
                        check(out_flit[k*FW +: FW] == e.flit, e.tag, "out_flit",
                              32'(out_flit[k*FW +: FW]), 32'(e.flit));
            end
        end
    end

    task automatic drain();
        idle(2, "drain");
        while (exp_q.size() > 0) @(negedge clk);
    endtask

    task automatic apply_reset();
        @(negedge clk);
        in_vld = 1'b0;
        rst = 1'b1;
        m_lock = 0;
        @(negedge clk);
        check(out_vld == 4'b0 && out_req == 4'b0 && !err, "R1", "outputs in reset",
              {23'b0, err, out_req, out_vld}, 32'b0);
        @(negedge clk);
        rst = 1'b0;
        check(out_vld == 4'b0 && out_req == 4'b0 && !err, "R1", "outputs after reset",
              {23'b0, err, out_req, out_vld}, 32'b0);
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        if (!finished) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog expired actual=%h expected=%h", 32'd0, 32'd1);
            $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
            $finish;
        end
    end

    initial begin
        apply_reset();
        // router (0,0)
        my_x = 1'b0; my_y = 1'b0;
        packet(1, 0, 0, "R2_east");
        packet(0, 1, 0, "R2_south");
        packet(1, 1, 2, "R2_x_first");      // R4, R5 with gaps
        // R6: back-to-back packets to different lines
        packet(1, 0, 0, "R6_first");
        packet(0, 1, 0, "R6_second");
        drain();
        // router (1,1)
        my_x = 1'b1; my_y = 1'b1;
        idle(1, "setup");
        packet(0, 1, 1, "R2_west");
        packet(1, 0, 0, "R2_north");
        packet(0, 0, 0, "R2_west_x_first");
        // R9: destination equals this router -> own direction
        drive(1'b1, head(1, 1), "R9_own_dir");
        drive(1'b1, body(6'h01), "R7_after_R9");
        // R7: orphan body and tail
        drive(1'b1, body(6'h3f), "R7_orphan_body");
        drive(1'b1, tail(6'h00), "R7_orphan_tail");
        // R8: head inside an open packet
        drive(1'b1, head(0, 0), "R8_open");
        drive(1'b1, head(1, 0), "R8_mid_head");
        idle(1, "R8_hold");
        drive(1'b1, body(6'h0c), "R8_body");
        // R10: reserved kind inside the packet, then the tail
        drive(1'b1, 8'h3c, "R10_rsvd");
        drive(1'b1, tail(6'h33), "R10_tail");
        drive(1'b1, 8'h00, "R10_rsvd_idle");
        drain();
        // R1: reset wipes an open path
        drive(1'b1, head(0, 1), "R1_open");
        drain();
        apply_reset();
        drive(1'b1, body(6'h11), "R1_orphan_after_reset");
        packet(1, 0, 0, "R3_after_reset");
        drain();
        finished = 1;
        $display("%0d/%0d checks passed", n_checks - n_fails, n_checks);
        $finish;
    end
endmodule